// File: doc/BRIEF.md
# GPIO Bank with Per-Line Interrupt Sensing

This block is a bank of up to 32 general-purpose lines controlled through a small 32-bit memory-mapped register port. Each line is independently a general input, a general output, or an interrupt input. Outputs are driven from an output-data register unless a per-line output-source bit hands the pin to another function. Input levels are observable through a gated input register, and they are visible on output lines too.

Interrupt lines pass through a synchroniser. They are then sensed either on level or on edge. A polarity bit picks active-high or rising versus active-low or falling, and a both-edge bit makes an edge line react to either transition. Edge events latch into a status register that software clears by writing ones. Level lines mirror the qualified input directly. A per-line enable register gates status into one combined interrupt output. Enable bits are set through a write-one-to-set port and cleared by writing zeros to the enable register.

The bus accepts one access per cycle while `bus_valid` is high. A read returns its data on `bus_rdata` one cycle later, and that value holds until the next read.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0 and `irq_out` is 0, so every line is a general input with interrupts disabled.
- R2: Registers decode at fixed byte offsets, one bit per line: 0x00 interrupt mode (1 = interrupt input), 0x04 direction (1 = output), 0x08 output data, 0x0C input data (read only), 0x10 status (read only), 0x14 status clear (write only), 0x18 enable, 0x1C enable set (write only), 0x20 polarity, 0x24 trigger (1 = edge, 0 = level), 0x40 output source, 0x4C both-edge, 0x50 input enable. Read data appears one cycle after the read request. Unmapped offsets and write-only offsets read 0.
- R3: `pin_oe` is 1 exactly for lines with direction 1 and mode 0. `pin_out` equals output data where the output-source bit is 0, and it is 0 where that bit is 1.
- R4: The input data register reads the pin value after a two-flop synchroniser, ANDed with the input-enable bits. It reflects the pin for output lines too, and writes to it are ignored.
- R5: A level line (mode 1, trigger 0) has a status bit equal to the synchronised pin XOR its polarity bit, updated every cycle. A status-clear write has no lasting effect on it.
- R6: An edge line with both-edge 0 latches status on a rising edge when polarity is 0 and on a falling edge when polarity is 1. The opposite edge neither sets nor clears that status.
- R7: An edge line with both-edge 1 latches status on either transition, whatever its polarity.
- R8: Writing 1 to a bit at 0x14 clears that line's latched edge status, and 0 bits leave status unchanged. An edge detected in the same cycle as the clear leaves the bit set.
- R9: Writing 1 to a bit at 0x1C sets that enable bit. Writing 0 to a bit at 0x18 clears that enable bit, and 1 bits leave it unchanged.
- R10: `irq_out` is 1 exactly when some line has both status and enable set.
- R11: A line whose mode bit is 0 reads status 0 whatever its pin does. A line taken out of interrupt mode loses its status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | NUM_LINES | Pin levels, asynchronous |
| pin_out | output | NUM_LINES | Output pin values |
| pin_oe | output | NUM_LINES | Output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an edge detected in the same cycle as a status-clear write to that line. The pin transition must be placed so that it leaves the synchroniser on exactly the edge where the clear is sampled. The stimulus changes the pin, waits two clock edges and then issues the clear write, and it expects the status bit still to read set afterwards. The reference model follows every pin, write and read on every clock, so other same-cycle orderings are also compared as they occur.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;
    localparam int MAX_LINES = 32;

    localparam logic [BUS_AW-1:0] OFS_MODE  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_DIR   = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_DOUT  = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_DIN   = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_STAT  = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_CLR   = 8'h14;
    localparam logic [BUS_AW-1:0] OFS_EN    = 8'h18;
    localparam logic [BUS_AW-1:0] OFS_ENSET = 8'h1C;
    localparam logic [BUS_AW-1:0] OFS_POL   = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_TRIG  = 8'h24;
    localparam logic [BUS_AW-1:0] OFS_OSRC  = 8'h40;
    localparam logic [BUS_AW-1:0] OFS_BOTH  = 8'h4C;
    localparam logic [BUS_AW-1:0] OFS_INEN  = 8'h50;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prev_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] chain;
        logic [N-1:0]             prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.chain[0] = pin_in;
        for (int s = 1; s < STAGES; s++) begin
            d.chain[s] = q.chain[s-1];
        end
        d.prev = q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl_o  = q.chain[LAST];
    assign prev_o = q.prev;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] mode_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] trig_i,
    input  logic [N-1:0] both_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);
    typedef struct packed {
        logic [N-1:0] stat;
    } det_t;

    det_t q, d;
    logic [N-1:0] hit;
    logic [N-1:0] active;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            logic rise, fall;
            assign rise = lvl_i[g] & ~prev_i[g];
            assign fall = ~lvl_i[g] & prev_i[g];
            assign hit[g] = both_i[g] ? (rise | fall)
                                      : (pol_i[g] ? fall : rise);
            assign active[g] = lvl_i[g] ^ pol_i[g];
        end
    endgenerate

    always_comb begin
        d      = q;
        d.stat = mode_i & ((~trig_i & active) |
                           (trig_i & ((q.stat & ~clr_i) | hit)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat_o = q.stat;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_irq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic [N-1:0]      lvl_i,
    input  logic [N-1:0]      stat_i,
    output logic [BUS_DW-1:0] rdata_o,
    output logic [N-1:0]      mode_o,
    output logic [N-1:0]      dir_o,
    output logic [N-1:0]      dout_o,
    output logic [N-1:0]      pol_o,
    output logic [N-1:0]      trig_o,
    output logic [N-1:0]      both_o,
    output logic [N-1:0]      osrc_o,
    output logic [N-1:0]      inen_o,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      clr_o
);
    typedef struct packed {
        logic [N-1:0]      mode;
        logic [N-1:0]      dir;
        logic [N-1:0]      dout;
        logic [N-1:0]      pol;
        logic [N-1:0]      trig;
        logic [N-1:0]      both;
        logic [N-1:0]      osrc;
        logic [N-1:0]      inen;
        logic [N-1:0]      en;
        logic [BUS_DW-1:0] rdata;
    } regs_t;

    regs_t q, d;
    logic [N-1:0] wbits;

    function automatic logic [BUS_DW-1:0] widen(input logic [N-1:0] v);
        return BUS_DW'(v);
    endfunction

    assign wbits = wdata[N-1:0];

    always_comb begin
        d     = q;
        clr_o = '0;
        if (wr_en) begin
            case (addr)
                OFS_MODE:  d.mode = wbits;
                OFS_DIR:   d.dir  = wbits;
                OFS_DOUT:  d.dout = wbits;
                OFS_POL:   d.pol  = wbits;
                OFS_TRIG:  d.trig = wbits;
                OFS_OSRC:  d.osrc = wbits;
                OFS_BOTH:  d.both = wbits;
                OFS_INEN:  d.inen = wbits;
                OFS_EN:    d.en   = q.en & wbits;
                OFS_ENSET: d.en   = q.en | wbits;
                OFS_CLR:   clr_o  = wbits;
                default:   ;
            endcase
        end
        if (rd_en) begin
            case (addr)
                OFS_MODE: d.rdata = widen(q.mode);
                OFS_DIR:  d.rdata = widen(q.dir);
                OFS_DOUT: d.rdata = widen(q.dout);
                OFS_DIN:  d.rdata = widen(lvl_i & q.inen);
                OFS_STAT: d.rdata = widen(stat_i);
                OFS_EN:   d.rdata = widen(q.en);
                OFS_POL:  d.rdata = widen(q.pol);
                OFS_TRIG: d.rdata = widen(q.trig);
                OFS_OSRC: d.rdata = widen(q.osrc);
                OFS_BOTH: d.rdata = widen(q.both);
                OFS_INEN: d.rdata = widen(q.inen);
                default:  d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata_o = q.rdata;
    assign mode_o  = q.mode;
    assign dir_o   = q.dir;
    assign dout_o  = q.dout;
    assign pol_o   = q.pol;
    assign trig_o  = q.trig;
    assign both_o  = q.both;
    assign osrc_o  = q.osrc;
    assign inen_o  = q.inen;
    assign en_o    = q.en;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic                 irq_out
);
    localparam int N = (NUM_LINES > MAX_LINES) ? MAX_LINES : NUM_LINES;

    logic [N-1:0] lvl_q, prev_q, stat_q, en_q, mode_q, trig_q;
    logic [N-1:0] dir_q, dout_q, pol_q, both_q, osrc_q, inen_q, clr_w;

    gpio_pin_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in[N-1:0]),
        .lvl_o  (lvl_q),
        .prev_o (prev_q)
    );

    gpio_bank_regs #(.N(N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_valid & bus_write),
        .rd_en   (bus_valid & ~bus_write),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .lvl_i   (lvl_q),
        .stat_i  (stat_q),
        .rdata_o (bus_rdata),
        .mode_o  (mode_q),
        .dir_o   (dir_q),
        .dout_o  (dout_q),
        .pol_o   (pol_q),
        .trig_o  (trig_q),
        .both_o  (both_q),
        .osrc_o  (osrc_q),
        .inen_o  (inen_q),
        .en_o    (en_q),
        .clr_o   (clr_w)
    );

    gpio_irq_detect #(.N(N)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_q),
        .prev_i (prev_q),
        .mode_i (mode_q),
        .pol_i  (pol_q),
        .trig_i (trig_q),
        .both_i (both_q),
        .clr_i  (clr_w),
        .stat_o (stat_q)
    );

    assign pin_oe  = NUM_LINES'(dir_q & ~mode_q);
    assign pin_out = NUM_LINES'(dout_q & ~osrc_q);
    assign irq_out = |(stat_q & en_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [N-1:0]      stat,
    input logic [N-1:0]      en,
    input logic [N-1:0]      mode,
    input logic [N-1:0]      trig
);
    logic clr_wr, en_wr, set_wr;
    assign clr_wr = bus_valid && bus_write && (bus_addr == OFS_CLR);
    assign en_wr  = bus_valid && bus_write && (bus_addr == OFS_EN);
    assign set_wr = bus_valid && bus_write && (bus_addr == OFS_ENSET);

    AST_NONIRQ_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(mode)) == '0)); // R11

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_wr) |-> (($past(stat & mode & trig) & ~stat) == '0)); // R6

    AST_ENSET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((en & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0]))); // R9

    AST_ENWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> ((en & ~$past(bus_wdata[N-1:0])) == '0)); // R9
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stat      (stat_q),
    .en        (en_q),
    .mode      (mode_q),
    .trig      (trig_q)
);

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pins = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_out;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    gpio_irq_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // behavioural reference model
    logic [31:0] m_s1, m_s2, m_prev, m_st, m_mode, m_dir, m_dout, m_pol;
    logic [31:0] m_trig, m_both, m_osrc, m_inen, m_en, m_rd, nst;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return m_mode;
            8'h04: return m_dir;
            8'h08: return m_dout;
            8'h0C: return m_s2 & m_inen;
            8'h10: return m_st;
            8'h18: return m_en;
            8'h20: return m_pol;
            8'h24: return m_trig;
            8'h40: return m_osrc;
            8'h4C: return m_both;
            8'h50: return m_inen;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_st <= '0; m_mode <= '0;
            m_dir <= '0; m_dout <= '0; m_pol <= '0; m_trig <= '0; m_both <= '0;
            m_osrc <= '0; m_inen <= '0; m_en <= '0; m_rd <= '0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                if (!m_mode[i]) nst[i] = 1'b0;
                else if (!m_trig[i]) nst[i] = m_s2[i] ^ m_pol[i];
                else begin
                    bit r, f, h, c;
                    r = m_s2[i] && !m_prev[i];
                    f = !m_s2[i] && m_prev[i];
                    h = m_both[i] ? (r || f) : (m_pol[i] ? f : r);
                    c = bus_valid && bus_write && bus_addr == 8'h14 && bus_wdata[i];
                    nst[i] = h || (m_st[i] && !c);
                end
            end
            m_st <= nst;
            if (bus_valid && !bus_write) m_rd <= model_read(bus_addr);
            if (bus_valid && bus_write) begin
                case (bus_addr)
                    8'h00: m_mode <= bus_wdata;
                    8'h04: m_dir  <= bus_wdata;
                    8'h08: m_dout <= bus_wdata;
                    8'h18: m_en   <= m_en & bus_wdata;
                    8'h1C: m_en   <= m_en | bus_wdata;
                    8'h20: m_pol  <= bus_wdata;
                    8'h24: m_trig <= bus_wdata;
                    8'h40: m_osrc <= bus_wdata;
                    8'h4C: m_both <= bus_wdata;
                    8'h50: m_inen <= bus_wdata;
                    default: ;
                endcase
            end
            m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check({31'h0, irq_out}, {31'h0, |(m_st & m_en)}, "R10 irq_out vs model");
            check(pin_oe, m_dir & ~m_mode, "R3 pin_oe vs model");
            check(pin_out, m_dout & ~m_osrc, "R3 pin_out vs model");
            check(bus_rdata, m_rd, "R2 rdata vs model");
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        check(bus_rdata, exp, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check(pin_oe, 32'h0, "R1 pin_oe after reset");
        check({31'h0, irq_out}, 32'h0, "R1 irq after reset");
        rd(8'h00, 32'h0, "R1 mode reset");
        rd(8'h18, 32'h0, "R1 enable reset");
        rd(8'h10, 32'h0, "R1 status reset");
        rd(8'h50, 32'h0, "R1 input enable reset");

        // R2 decode and readback
        wr(8'h04, 32'hA5A5_0F0F);
        rd(8'h04, 32'hA5A5_0F0F, "R2 direction readback");
        wr(8'h4C, 32'h1234_8000);
        rd(8'h4C, 32'h1234_8000, "R2 both-edge readback");
        rd(8'h2C, 32'h0, "R2 unmapped 0x2C");
        rd(8'hFC, 32'h0, "R2 unmapped 0xFC");
        rd(8'h14, 32'h0, "R2 clear reads 0");
        wr(8'h4C, 32'h0);

        // R3 output path
        wr(8'h04, 32'h0000_00FF);
        wr(8'h08, 32'h0000_0F0F);
        wr(8'h40, 32'h0000_0003);
        check(pin_oe, 32'h0000_00FF, "R3 oe from direction");
        check(pin_out, 32'h0000_0F0C, "R3 out with source select");
        wr(8'h00, 32'h0000_0001);
        check(pin_oe, 32'h0000_00FE, "R3 interrupt line not driven");
        wr(8'h00, 32'h0);

        // R4 input path
        pins = 32'h1234_5678;
        idle(3);
        rd(8'h0C, 32'h0, "R4 input gated off");
        wr(8'h50, 32'hFFFF_00FF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h1234_0078, "R4 input incl output lines");
        pins = 32'h0;
        idle(3);
        rd(8'h0C, 32'h0, "R4 input follows pins");

        // interrupt configuration
        wr(8'h24, 32'h0000_0700);
        wr(8'h20, 32'h0000_0620);
        wr(8'h4C, 32'h0000_0400);
        wr(8'h00, 32'h0000_0730);
        idle(3);
        rd(8'h10, 32'h0000_0020, "R5 active-low level");
        wr(8'h1C, 32'h0000_0030);
        check({31'h0, irq_out}, 32'h1, "R10 irq on enabled status");
        pins[4] = 1'b1;
        idle(3);
        rd(8'h10, 32'h0000_0030, "R5 active-high level");
        wr(8'h14, 32'h0000_0030);
        idle(1);
        rd(8'h10, 32'h0000_0030, "R5 clear no effect on level");
        pins[4] = 1'b0;
        idle(3);
        rd(8'h10, 32'h0000_0020, "R5 level not latched");
        wr(8'h18, 32'hFFFF_FFDF);
        rd(8'h18, 32'h0000_0010, "R9 zero bit clears enable");
        check({31'h0, irq_out}, 32'h0, "R10 irq off after disable");

        // R6 single edges
        pins[8] = 1'b1; idle(3);
        rd(8'h10, 32'h0000_0120, "R6 rising edge latched");
        pins[8] = 1'b0; idle(3);
        rd(8'h10, 32'h0000_0120, "R6 sticky over opposite edge");
        wr(8'h14, 32'h0000_0100); idle(1);
        rd(8'h10, 32'h0000_0020, "R8 clear edge status");
        pins[9] = 1'b1; idle(3);
        rd(8'h10, 32'h0000_0020, "R6 falling line ignores rise");
        pins[9] = 1'b0; idle(3);
        rd(8'h10, 32'h0000_0220, "R6 falling edge latched");
        wr(8'h14, 32'h0000_0200); idle(1);

        // R7 both edges
        pins[10] = 1'b1; idle(3);
        rd(8'h10, 32'h0000_0420, "R7 rise on both-edge line");
        wr(8'h14, 32'h0000_0400);
        pins[10] = 1'b0; idle(3);
        rd(8'h10, 32'h0000_0420, "R7 fall on both-edge line");
        wr(8'h14, 32'h0000_0400); idle(1);

        // R8 set wins over simultaneous clear, zero bits ignored
        pins[9] = 1'b1; idle(3);
        pins[9] = 1'b0; idle(3);
        pins[8] = 1'b1;
        idle(2);
        wr(8'h14, 32'h0000_0100);
        idle(1);
        rd(8'h10, 32'h0000_0320, "R8 set beats clear, zero bits keep");
        wr(8'h14, 32'h0000_0300); idle(1);
        rd(8'h10, 32'h0000_0020, "R8 both cleared");

        // R9 enable set / clear
        wr(8'h1C, 32'h0000_0300);
        rd(8'h18, 32'h0000_0310, "R9 enable set");
        wr(8'h18, 32'hFFFF_FEFF);
        rd(8'h18, 32'h0000_0210, "R9 ones keep enable");
        check({31'h0, irq_out}, 32'h0, "R10 no pending");
        pins[9] = 1'b0; pins[8] = 1'b0; idle(1);
        pins[9] = 1'b1; idle(3);
        pins[9] = 1'b0; idle(3);
        check({31'h0, irq_out}, 32'h1, "R10 pending line 9");

        // R11 non-interrupt lines
        pins[12] = 1'b1; idle(3);
        pins[12] = 1'b0; idle(3);
        rd(8'h10, 32'h0000_0220, "R11 gpio line no status");
        wr(8'h00, 32'h0000_0530);
        idle(2);
        rd(8'h10, 32'h0000_0020, "R11 status dropped leaving irq mode");
        check({31'h0, irq_out}, 32'h0, "R11 irq dropped");

        idle(2);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule